// File: doc/BRIEF.md
# Multi-Channel Isochronous Transmit Sequencer

This block belongs to the transmit side of a serial-bus link layer. It sends a burst of isochronous packets in one isochronous period. A start-of-period strobe launches the burst. A two-bit count field sets how many packets the burst holds, from one to four. Each packet has its own header. In insert mode the headers come from four header registers, walked in ascending slot order. The payload quadlets come from a data-mover port through a valid/request handshake.

When insertion is turned off, the data mover supplies each header itself as the first word of its packet. The block decodes that header in the same way as a register header. Output packets leave as a word stream with start and end markers.

The block does not check whether headers carry different channel numbers. A strobe that arrives while a burst is still running does not restart it. Instead it sets a sticky overrun flag, and the burst in flight runs to its end.

Top module: `iso_burst_tx`

## Requirements
- R1: A strobe on `period_start_i` while idle starts a burst only when `iso_tx_en_i` is 1. With `iso_tx_en_i` at 0 the strobe is ignored: no words are emitted and `busy_o` stays 0.
- R2: A burst holds exactly `chan_cnt_i`+1 packets. Both the count and the insert mode are sampled at the strobe that starts the burst.
- R3: In insert mode, header slot k is `hdr_regs_i[32*k+31:32*k]`. Packets go out in ascending slot order, starting with slot 0.
- R4: Each packet's first word is its header, marked with `pkt_sop_o`. Header bits [31:16] give the payload length in bytes. The payload is ceil(length/4) words, and `pkt_eop_o` marks the final word. A zero-length packet is a single word carrying both markers.
- R5: With `hdr_insert_ni`=0, the header comes from the register slot and only the payload is drawn from the data mover. With `hdr_insert_ni`=1, each header is also drawn from the data mover as the first word of its packet.
- R6: The channel numbers in the headers are not checked. Identical headers are sent unchanged.
- R7: `dm_req_o` is high only while a data-mover word is wanted. A word is consumed when both `dm_req_o` and `dm_valid_i` are high at a clock edge. Every consumed word appears exactly once on the output, in order, one cycle later. Stalls on `dm_valid_i` insert gaps but never drop or repeat a word.
- R8: After the last packet the block returns to idle. It ignores data-mover words until the next accepted strobe.
- R9: A strobe that arrives while `busy_o` is high sets `overrun_o`. The flag stays set until reset. The running burst completes unchanged and no new burst starts.
- R10: After reset, `pkt_valid_o`, `pkt_sop_o`, `pkt_eop_o`, `dm_req_o`, `busy_o` and `overrun_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| period_start_i | input | 1 | Start-of-isochronous-period strobe |
| iso_tx_en_i | input | 1 | Isochronous transmit mode enable |
| chan_cnt_i | input | 2 | Packets per period minus one |
| hdr_insert_ni | input | 1 | 0: insert headers from registers; 1: headers come from the data mover |
| hdr_regs_i | input | 128 | Four 32-bit header slots, slot 0 in the low bits |
| dm_req_o | output | 1 | Data mover word request |
| dm_valid_i | input | 1 | Data mover word valid |
| dm_data_i | input | 32 | Data mover word |
| pkt_valid_o | output | 1 | Output word valid |
| pkt_data_o | output | 32 | Output word |
| pkt_sop_o | output | 1 | First word of packet |
| pkt_eop_o | output | 1 | Last word of packet |
| busy_o | output | 1 | Burst in progress |
| overrun_o | output | 1 | Sticky strobe-while-busy flag |

## Verification
The bench mixes random bursts with directed cases.

- **Zero-length packets.** A design that always expects at least one payload word would hang, or would swallow the next packet's header.
- **Non-multiple-of-four lengths.** Rounding down would lose the tail quadlet.
- **Duplicate headers.** A design that filtered repeated channels would emit too few packets.
- **Strobe while busy.** A restart would repeat headers, and a missing flag would leave `overrun_o` low.
- **Disabled strobe and idle data-mover traffic.** A design that leaks into these cases would emit words or consume data it should leave alone.

// File: rtl/iso_tx_pkg.sv
package iso_tx_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_HDR, ST_PAY} seq_st_e;
  localparam int LEN_LSB = 16;
  localparam int LEN_W   = 16;
endpackage

// File: rtl/iso_hdr_sel.sv
module iso_hdr_sel #(
  parameter int DW    = 32,
  parameter int SLOTS = 4,
  localparam int IW   = $clog2(SLOTS)
) (
  input  logic [SLOTS*DW-1:0] regs_i,
  input  logic [IW-1:0]       idx_i,
  output logic [DW-1:0]       hdr_o
);
  logic [DW-1:0] slot [SLOTS];
  for (genvar k = 0; k < SLOTS; k++) begin : g_slot
    assign slot[k] = regs_i[k*DW +: DW];
  end
  assign hdr_o = slot[idx_i];
endmodule

// File: rtl/iso_len_calc.sv
module iso_len_calc
  import iso_tx_pkg::*;
#(
  parameter int DW = 32,
  parameter int QW = LEN_W - 1
) (
  input  logic [DW-1:0] hdr_i,
  output logic [QW-1:0] quads_o
);
  logic [LEN_W:0] bytes_up;
  // round byte length up to whole quadlets
  assign bytes_up = {1'b0, hdr_i[LEN_LSB +: LEN_W]} + (LEN_W+1)'(3);
  assign quads_o  = bytes_up[2 +: QW];
endmodule

// File: rtl/iso_seq_ctrl.sv
module iso_seq_ctrl
  import iso_tx_pkg::*;
#(
  parameter int DW = 32,
  parameter int QW = 15,
  parameter int IW = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          period_start_i,
  input  logic          iso_en_i,
  input  logic [IW-1:0] cnt_i,
  input  logic          hdr_insert_ni,
  input  logic [DW-1:0] hdr_word_i,
  input  logic [QW-1:0] quads_i,
  input  logic          dm_valid_i,
  input  logic [DW-1:0] dm_data_i,
  output logic          dm_req_o,
  output logic [IW-1:0] idx_o,
  output logic          ins_o,
  output logic          vld_o,
  output logic [DW-1:0] dat_o,
  output logic          sop_o,
  output logic          eop_o,
  output logic          busy_o,
  output logic          ovr_o
);
  seq_st_e       st_q;
  logic [IW-1:0] idx_q, last_q;
  logic [QW-1:0] rem_q;
  logic          ins_q, vld_q, sop_q, eop_q, ovr_q;
  logic [DW-1:0] dat_q;
  logic          hdr_go, pkt_done;

  assign hdr_go   = (st_q == ST_HDR) && (ins_q || dm_valid_i);
  assign pkt_done = (hdr_go && quads_i == '0) ||
                    (st_q == ST_PAY && dm_valid_i && rem_q == QW'(1));
  assign dm_req_o = (st_q == ST_PAY) || (st_q == ST_HDR && !ins_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      idx_q  <= '0;
      last_q <= '0;
      rem_q  <= '0;
      ins_q  <= 1'b0;
      vld_q  <= 1'b0;
      sop_q  <= 1'b0;
      eop_q  <= 1'b0;
      ovr_q  <= 1'b0;
      dat_q  <= '0;
    end else begin
      vld_q <= 1'b0;
      sop_q <= 1'b0;
      eop_q <= 1'b0;
      if (period_start_i && st_q != ST_IDLE) ovr_q <= 1'b1;
      case (st_q)
        ST_IDLE: if (period_start_i && iso_en_i) begin
          idx_q  <= '0;
          last_q <= cnt_i;
          ins_q  <= !hdr_insert_ni;
          st_q   <= ST_HDR;
        end
        ST_HDR: if (hdr_go) begin
          vld_q <= 1'b1;
          dat_q <= hdr_word_i;
          sop_q <= 1'b1;
          eop_q <= (quads_i == '0);
          rem_q <= quads_i;
          st_q  <= ST_PAY;
        end
        ST_PAY: if (dm_valid_i) begin
          vld_q <= 1'b1;
          dat_q <= dm_data_i;
          eop_q <= (rem_q == QW'(1));
          rem_q <= rem_q - QW'(1);
        end
        default: st_q <= ST_IDLE;
      endcase
      // step to next header slot or finish burst
      if (pkt_done) begin
        if (idx_q == last_q) st_q <= ST_IDLE;
        else begin
          idx_q <= idx_q + IW'(1);
          st_q  <= ST_HDR;
        end
      end
    end
  end

  assign idx_o  = idx_q;
  assign ins_o  = ins_q;
  assign vld_o  = vld_q;
  assign dat_o  = dat_q;
  assign sop_o  = sop_q;
  assign eop_o  = eop_q;
  assign busy_o = (st_q != ST_IDLE);
  assign ovr_o  = ovr_q;

  AST_START_SLOT0: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_IDLE && period_start_i && iso_en_i) |=> (st_q == ST_HDR && idx_q == '0)); // R3
  AST_DISABLED_STAYS_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_IDLE && !(period_start_i && iso_en_i)) |=> st_q == ST_IDLE); // R1
  AST_IDX_IN_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q != ST_IDLE) |-> idx_q <= last_q); // R2
  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_IDLE && $past(st_q) == ST_IDLE) |-> !vld_q); // R8
  AST_OVR_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovr_q |=> ovr_q); // R9
  AST_SOP_HAS_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sop_q |-> vld_q); // R4
  AST_PAY_REMAINING: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_PAY) |-> rem_q != '0); // R4
  AST_PAY_STALL_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_PAY && !dm_valid_i) |=> (!vld_q && $stable(rem_q))); // R7
endmodule

// File: rtl/iso_burst_tx.sv
module iso_burst_tx
  import iso_tx_pkg::*;
#(
  parameter int DW    = 32,
  parameter int SLOTS = 4,
  localparam int IW   = $clog2(SLOTS),
  localparam int QW   = LEN_W - 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              period_start_i,
  input  logic              iso_tx_en_i,
  input  logic [IW-1:0]     chan_cnt_i,
  input  logic              hdr_insert_ni,
  input  logic [SLOTS*DW-1:0] hdr_regs_i,
  output logic              dm_req_o,
  input  logic              dm_valid_i,
  input  logic [DW-1:0]     dm_data_i,
  output logic              pkt_valid_o,
  output logic [DW-1:0]     pkt_data_o,
  output logic              pkt_sop_o,
  output logic              pkt_eop_o,
  output logic              busy_o,
  output logic              overrun_o
);
  logic [IW-1:0] idx;
  logic          ins;
  logic [DW-1:0] reg_hdr, hdr_word;
  logic [QW-1:0] quads;

  iso_hdr_sel #(.DW(DW), .SLOTS(SLOTS)) u_hdr_sel (
    .regs_i (hdr_regs_i),
    .idx_i  (idx),
    .hdr_o  (reg_hdr)
  );

  assign hdr_word = ins ? reg_hdr : dm_data_i;

  iso_len_calc #(.DW(DW), .QW(QW)) u_len (
    .hdr_i   (hdr_word),
    .quads_o (quads)
  );

  iso_seq_ctrl #(.DW(DW), .QW(QW), .IW(IW)) u_ctrl (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .period_start_i (period_start_i),
    .iso_en_i       (iso_tx_en_i),
    .cnt_i          (chan_cnt_i),
    .hdr_insert_ni  (hdr_insert_ni),
    .hdr_word_i     (hdr_word),
    .quads_i        (quads),
    .dm_valid_i     (dm_valid_i),
    .dm_data_i      (dm_data_i),
    .dm_req_o       (dm_req_o),
    .idx_o          (idx),
    .ins_o          (ins),
    .vld_o          (pkt_valid_o),
    .dat_o          (pkt_data_o),
    .sop_o          (pkt_sop_o),
    .eop_o          (pkt_eop_o),
    .busy_o         (busy_o),
    .ovr_o          (overrun_o)
  );
endmodule

// File: tb/iso_burst_tx_bench.sv
module iso_burst_tx_bench;
  logic         clk = 0;
  logic         rst_n = 0;
  logic         start = 0, iso_en = 0, ins_n = 0;
  logic [1:0]   cnt = 0;
  logic [127:0] hregs = '0;
  logic         dm_req, dm_valid = 0;
  logic [31:0]  dm_data = 0;
  logic         p_vld, p_sop, p_eop, busy, ovr;
  logic [31:0]  p_dat;

  int n_tests = 0, n_fail = 0;
  logic [31:0] dm_q[$];
  int          dm_ptr = 0;
  bit          force_valid = 0;
  int          stall_pct = 0;
  logic [33:0] rx_q[$];
  logic [33:0] ex_q[$];

  always #2.5 clk = ~clk;

  iso_burst_tx u_iso_burst_tx (
    .clk_i(clk), .rst_ni(rst_n), .period_start_i(start), .iso_tx_en_i(iso_en),
    .chan_cnt_i(cnt), .hdr_insert_ni(ins_n), .hdr_regs_i(hregs),
    .dm_req_o(dm_req), .dm_valid_i(dm_valid), .dm_data_i(dm_data),
    .pkt_valid_o(p_vld), .pkt_data_o(p_dat), .pkt_sop_o(p_sop), .pkt_eop_o(p_eop),
    .busy_o(busy), .overrun_o(ovr));

  task automatic chk(bit ok, string req, logic [63:0] act, logic [63:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mk_hdr(int len, int chan);
    return {len[15:0], 2'b01, chan[5:0], 4'hA, 4'h0};
  endfunction

  function automatic int quads(logic [31:0] h);
    return (int'(h[31:16]) + 3) / 4;
  endfunction

  // data mover model: word consumed when req && valid at an edge
  initial begin
    bit take = 0;
    forever begin
      @(negedge clk);
      if (take) dm_ptr++;
      dm_data  = (dm_ptr < dm_q.size()) ? dm_q[dm_ptr] : 32'hDEAD_0000;
      dm_valid = force_valid ||
                 ((dm_ptr < dm_q.size()) && (($urandom % 100) >= stall_pct));
      take = dm_req && dm_valid;
    end
  end

  initial begin
    forever begin
      @(negedge clk);
      if (p_vld) rx_q.push_back({p_sop, p_eop, p_dat});
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++; n_tests++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  task automatic pulse_start();
    @(negedge clk); start = 1;
    @(negedge clk); start = 0;
  endtask

  task automatic wait_idle();
    int t = 0;
    while (busy && t < 2000) begin @(negedge clk); t++; end
    repeat (3) @(negedge clk);
  endtask

  // build stimulus and expected stream, run one period, compare
  task automatic run_period(int c, bit insn, logic [31:0] h[4], bit inject_ovr, string tag);
    int sops = 0;
    int pay = 32'h5000_0000 + ($urandom % 4096) * 256;
    dm_q.delete(); dm_ptr = 0; rx_q.delete(); ex_q.delete();
    for (int k = 0; k < 4; k++) hregs[k*32 +: 32] = h[k];
    for (int p = 0; p <= c; p++) begin
      int q = quads(h[p]);
      if (insn) dm_q.push_back(h[p]);
      ex_q.push_back({1'b1, q == 0, h[p]});
      for (int w = 0; w < q; w++) begin
        dm_q.push_back(pay);
        ex_q.push_back({1'b0, w == q - 1, pay[31:0]});
        pay++;
      end
    end
    @(negedge clk); cnt = c[1:0]; ins_n = insn; iso_en = 1;
    pulse_start();
    cnt = ~c[1:0]; ins_n = ~insn;
    if (inject_ovr) begin
      @(negedge clk); start = 1; @(negedge clk); start = 0;
    end
    wait_idle();
    chk(rx_q.size() == ex_q.size(), {tag, " R2 R4 word count"}, rx_q.size(), ex_q.size());
    for (int i = 0; i < rx_q.size() && i < ex_q.size(); i++) begin
      chk(rx_q[i] == ex_q[i], {tag, " R3 R4 R5 R6 word"}, rx_q[i], ex_q[i]);
      if (rx_q[i][33]) sops++;
    end
    chk(sops == c + 1, {tag, " R2 packets"}, sops, c + 1);
    chk(dm_ptr == dm_q.size(), {tag, " R7 dm words consumed"}, dm_ptr, dm_q.size());
  endtask

  initial begin
    logic [31:0] h[4];
    int unsigned seed = $urandom(32'h1394);
    #1;
    chk(!p_vld && !p_sop && !p_eop && !dm_req && !busy && !ovr, "R10 reset outputs",
        {p_vld, p_sop, p_eop, dm_req, busy, ovr}, 0);
    repeat (3) @(negedge clk); rst_n = 1;
    repeat (2) @(negedge clk);
    chk(!busy && !ovr, "R10 after release", {busy, ovr}, 0);

    // R1: strobe with iso disabled ignored
    iso_en = 0; dm_q = '{32'h1, 32'h2}; dm_ptr = 0; rx_q.delete(); force_valid = 1;
    pulse_start();
    repeat (10) @(negedge clk);
    chk(!busy && rx_q.size() == 0 && dm_ptr == 0, "R1 disabled strobe ignored",
        {busy, 8'(rx_q.size()), 8'(dm_ptr)}, 0);
    force_valid = 0;

    // R4: zero-length and odd-length headers, insert mode
    h = '{mk_hdr(0, 3), mk_hdr(5, 4), mk_hdr(0, 5), mk_hdr(12, 6)};
    run_period(3, 0, h, 0, "zero/odd");
    // R5: headers from data mover
    h = '{mk_hdr(7, 1), mk_hdr(0, 2), mk_hdr(4, 3), mk_hdr(1, 4)};
    stall_pct = 40;
    run_period(3, 1, h, 0, "dm headers");
    // R6: duplicate channels
    h = '{mk_hdr(8, 9), mk_hdr(8, 9), mk_hdr(8, 9), mk_hdr(0, 0)};
    run_period(2, 0, h, 0, "duplicates");
    chk(!ovr, "R9 no overrun yet", ovr, 0);

    // R8: idle ignores data mover traffic
    dm_q = '{32'hAAAA_0001, 32'hAAAA_0002}; dm_ptr = 0; rx_q.delete(); force_valid = 1;
    repeat (20) @(negedge clk);
    chk(rx_q.size() == 0 && dm_ptr == 0 && !dm_req, "R8 idle ignores payload",
        {8'(rx_q.size()), 8'(dm_ptr)}, 0);
    force_valid = 0;

    // random periods
    for (int r = 0; r < 40; r++) begin
      for (int k = 0; k < 4; k++) h[k] = mk_hdr($urandom % 14, $urandom % 64);
      stall_pct = $urandom % 60;
      run_period($urandom % 4, $urandom % 2, h, 0, "random");
    end

    // R9: strobe while busy
    h = '{mk_hdr(16, 1), mk_hdr(16, 2), mk_hdr(4, 3), mk_hdr(4, 4)};
    stall_pct = 20;
    run_period(1, 0, h, 1, "overrun R9");
    chk(ovr == 1, "R9 overrun set", ovr, 1);
    run_period(0, 0, h, 0, "after overrun");
    chk(ovr == 1, "R9 overrun sticky", ovr, 1);
    @(negedge clk); rst_n = 0; @(negedge clk);
    chk(!ovr, "R9 R10 overrun cleared by reset", ovr, 0);
    rst_n = 1;
    repeat (2) @(negedge clk);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule